// File: doc/BRIEF.md
# Two-Phase Latched LCD Word Writer

This block delivers one 16-bit word to a parallel LCD controller over an 8-bit output bus that works with an external transparent latch. The upper byte goes out first while the latch is open, the latch is closed so that it holds that byte on the panel's upper data lines, and then the lower byte goes out on the same eight pins. The panel therefore sees all sixteen lines valid together, while the chip spends only nine pins on the data path.

The block also drives the register-select line (command or data) and the active-low write strobe. It places every edge on a fixed clock count, so that the whole write fits in the panel's write window, derived from the clock period. A requester raises `go` for one cycle and watches `busy`. The word and select value are captured when the request is accepted. Several requesters can share the block by waiting for `busy` to be low.

Top module: `split_word_lcd_tx`

## Requirements
- R1: After reset, and whenever no write is in progress, `busy` is 0, `lcd_wr_n` is 1, `lcd_le` is 0, `lcd_data` is 8'h00 and `lcd_rs` is 0.
- R2: A `go` sampled high while `busy` is low starts a write: `busy` is high from the next cycle for exactly NCYC cycles, then low.
- R3: In the first busy cycle `lcd_le` is 1 and `lcd_data` carries word bits [15:8]. In the second busy cycle `lcd_le` is 0 while `lcd_data` still carries bits [15:8], so the latch closes on a steady byte.
- R4: From the third busy cycle to the last one, `lcd_data` carries word bits [7:0].
- R5: `lcd_wr_n` is low from the third busy cycle through busy cycle NCYC-1, which is NCYC-3 cycles. It returns high in the last busy cycle, and the data and select lines have been steady for at least one cycle before it rises.
- R6: `lcd_rs` holds, for every busy cycle, the value of `rs_in` that was sampled when the write was accepted (1 = data, 0 = command).
- R7: `word_in` and `rs_in` are registered on acceptance. Changing them while `busy` is high does not alter the word or the select value delivered.
- R8: A `go` that arrives while `busy` is high is dropped. It neither extends nor restarts the current write, and it does not start a later one.
- R9: NCYC is the larger of 4 and ceil(WRITE_PS / CLK_PS).
- R10: `lcd_le` is never high in a cycle where `lcd_wr_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle request to start a write |
| word_in | input | 16 | Word to send to the panel |
| rs_in | input | 1 | Register select for the word: 1 = data, 0 = command |
| busy | output | 1 | High while a write is in progress |
| lcd_data | output | 8 | Shared byte bus to the latch and the panel's lower lines |
| lcd_le | output | 1 | Enable of the external transparent latch |
| lcd_rs | output | 1 | Register-select line to the panel |
| lcd_wr_n | output | 1 | Active-low write strobe; the panel captures on its rising edge |

## Verification
The bench builds the block with an 8 ns clock period and a 70 ns write window. The division leaves a remainder, so the round-up gives a nine-cycle write (72 ns), not the seven cycles of the default. This makes the strobe's low phase six cycles long, which shows that every edge follows the derived count and not a fixed one. An external latch modelled in the bench rebuilds the 16-bit word at each strobe rise. Stray requests and changes to the inputs are issued in the middle of a write to confirm that the captured values are the ones delivered.

// File: rtl/split_word_lcd_tx.sv
module split_word_lcd_tx #(
  parameter int CLK_PS   = 10000,
  parameter int WRITE_PS = 70000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [15:0] word_in,
  input  logic        rs_in,
  output logic        busy,
  output logic [7:0]  lcd_data,
  output logic        lcd_le,
  output logic        lcd_rs,
  output logic        lcd_wr_n
);
  // R9: window length, at least 4 cycles so the strobe edges fit
  localparam int RAW  = (WRITE_PS + CLK_PS - 1) / CLK_PS;
  localparam int NCYC = (RAW < 4) ? 4 : RAW;
  localparam int CW   = $clog2(NCYC);
  localparam logic [CW-1:0] LAST     = CW'(NCYC - 1);
  localparam logic [CW-1:0] LO_START = CW'(2);

  logic [CW-1:0] cnt;
  logic [15:0]   word_q;
  logic          rs_q;
  logic          lo_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
      rs_q   <= 1'b0;
    end else if (!busy) begin
      if (go) begin
        busy   <= 1'b1;
        cnt    <= '0;
        word_q <= word_in;
        rs_q   <= rs_in;
      end
    end else if (cnt == LAST) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign lo_phase = busy && (cnt >= LO_START);
  assign lcd_le   = busy && (cnt == '0);
  assign lcd_data = !busy ? 8'h00 : (lo_phase ? word_q[7:0] : word_q[15:8]);
  assign lcd_rs   = busy & rs_q;
  assign lcd_wr_n = !(lo_phase && (cnt != LAST));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_wr_n && !lcd_le && lcd_data == 8'h00 && !lcd_rs));

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> busy);

  assert_le_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_le) |-> (busy && $stable(lcd_data)));

  assert_wr_rise_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_wr_n) |-> (busy && $stable(lcd_data) && $stable(lcd_rs)));

  assert_rs_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lcd_rs));

  assert_drop_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> ($stable(word_q) && $stable(rs_q)));

  assert_le_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcd_le && !lcd_wr_n));
endmodule

// File: tb/split_word_lcd_tx_tb.sv
module split_word_lcd_tx_tb;
  localparam int NCYC = 9; // R9: ceil(70000/8000) = 9

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] word_in = '0;
  logic        rs_in = 1'b0;
  logic        busy;
  logic [7:0]  lcd_data;
  logic        lcd_le, lcd_rs, lcd_wr_n;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  split_word_lcd_tx #(.CLK_PS(8000), .WRITE_PS(70000)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .word_in(word_in), .rs_in(rs_in),
    .busy(busy), .lcd_data(lcd_data), .lcd_le(lcd_le), .lcd_rs(lcd_rs),
    .lcd_wr_n(lcd_wr_n)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(busy == 1'b0, {tag, " busy"}, int'(busy), 0);
    chk(lcd_wr_n == 1'b1 && lcd_le == 1'b0, {tag, " wr_n/le"},
        int'({lcd_wr_n, lcd_le}), 2);
    chk(lcd_data == 8'h00 && lcd_rs == 1'b0, {tag, " data/rs"},
        int'({lcd_rs, lcd_data}), 0);
  endtask

  // one write; poke=1 changes inputs and pulses go mid-write (R7, R8)
  task automatic run_write(input logic [15:0] w, input logic r, input bit poke, input string name);
    logic [7:0]  latch = 8'h00;
    logic [15:0] got = 16'h0;
    logic        got_rs = 1'b0;
    logic        prev_wr = 1'b1;
    int busy_n = 0, le_n = 0, low_n = 0, strobes = 0, le_bad = 0, lo_bad = 0;
    @(negedge clk);
    word_in = w; rs_in = r; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    if (poke) begin word_in = ~w; rs_in = ~r; end
    for (int i = 0; i < 20; i++) begin
      if (busy) busy_n++;
      if (lcd_le) begin
        le_n++;
        latch = lcd_data;
        if (i != 0 || lcd_data != w[15:8]) le_bad++;
      end
      if (i == 1 && (lcd_le || lcd_data != w[15:8])) le_bad++;
      if (i >= 2 && i < NCYC && lcd_data != w[7:0]) lo_bad++;
      if (!lcd_wr_n) low_n++;
      if (!prev_wr && lcd_wr_n) begin
        strobes++;
        got = {latch, lcd_data};
        got_rs = lcd_rs;
      end
      prev_wr = lcd_wr_n;
      if (poke && i == 2) go = 1'b1;
      if (poke && i == 3) go = 1'b0;
      @(negedge clk);
    end
    chk(busy_n == NCYC, {name, " R2 R9 busy cycles"}, busy_n, NCYC);
    chk(le_n == 1 && le_bad == 0, {name, " R3 latch phase"}, le_bad, 0);
    chk(lo_bad == 0, {name, " R4 low byte phase"}, lo_bad, 0);
    chk(low_n == NCYC - 3 && strobes == 1, {name, " R5 strobe low cycles"}, low_n, NCYC - 3);
    chk(got == w, {name, " R7 R8 panel word"}, int'(got), int'(w));
    chk(got_rs == r, {name, " R6 rs"}, int'(got_rs), int'(r));
    check_idle({name, " R1 idle after"});
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");
  endtask

  task automatic test_le_excl;
    int bad = 0;
    @(negedge clk);
    go = 1'b1; word_in = 16'h3C96; rs_in = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < NCYC + 2; i++) begin
      if (lcd_le && !lcd_wr_n) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 latch/strobe overlap", bad, 0);
  endtask

  initial begin
    test_reset();
    run_write(16'hA55A, 1'b1, 1'b0, "data A55A");
    run_write(16'h0000, 1'b0, 1'b0, "cmd 0000");
    run_write(16'hFFFF, 1'b1, 1'b0, "data FFFF");
    run_write(16'h12C3, 1'b0, 1'b1, "poked 12C3");
    run_write(16'h8001, 1'b1, 1'b1, "poked 8001");
    test_le_excl();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule